// File: doc/BRIEF.md
# Maskable Interrupt Enable and Acceptance Unit

This block holds the maskable-interrupt enable state of an 8-bit processor core and decides, once per instruction, whether a pending request is taken. An external instruction sequencer supplies decoded strobes: a last-cycle marker, enable, disable, return-from-service-with-restore, load-accumulator-from-base-page/refresh register, and halt. The unit also receives an active-low request line, the interrupt base-page register and a vector byte from the data bus.

Its outputs are a one-clock acceptance pulse, the parity/overflow flag bit produced by a base-page/refresh load, a 16-bit vector pointer for vectored mode, a halt wake pulse and the refresh counter value. The enable state is kept as a primary and a backup flip-flop. A selectable flag-sample point reproduces a known hazard. When a request is taken in the final clock of a base-page/refresh load, the flag is copied from the backup enable after acceptance has already cleared it. The flag then reads 0 although interrupts were enabled when the load began.

Top module: `cpu_irq_gate`

## Requirements
- R1: After reset, take_o, wake_o and pv_o are 0, vec_ptr_o is 0000h, refresh_o is 00h, and both enables are cleared.
- R2: take_o is 1 for exactly one clock after a rising edge at which step_last=1, irq_n=0 and the primary enable is 1, unless the acceptance block of R4 applies. Otherwise take_o is 0.
- R3: Acceptance clears both enables at the same edge. A request still held low is then not taken again, and a following load reads flag 0.
- R4: cmd_enable with step_last sets both enables. Acceptance is blocked in the final clock of that enable instruction and in the final clock of the next instruction.
- R5: cmd_disable with step_last clears both enables. cmd_restore with step_last copies the backup enable into the primary enable, so the enable state is unchanged while the two are equal.
- R6: cmd_ld_ir with step_last loads pv_o with the backup enable. If a request is accepted at that same edge, pv_o becomes 0.
- R7: On acceptance, vec_ptr_o becomes {base_page_i, bus_vec_i}, with the base page as the high byte. For example, 80h with FFh gives 80FFh. It holds between acceptances.
- R8: Each edge with step_last=1 increments bits 6:0 of refresh_o modulo 128, and bit 7 keeps its value. refresh_load writes all 8 bits of refresh_din and takes priority over the increment.
- R9: cmd_halt with step_last enters the halted state. wake_o pulses together with take_o when a request is accepted while halted, or in the final clock of the halt itself. With interrupts disabled, wake_o never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_last | input | 1 | Final clock of the current instruction |
| cmd_enable | input | 1 | Enable-interrupts instruction strobe |
| cmd_disable | input | 1 | Disable-interrupts instruction strobe |
| cmd_restore | input | 1 | Return-from-service with enable restore strobe |
| cmd_ld_ir | input | 1 | Load accumulator from base-page or refresh register |
| cmd_halt | input | 1 | Halt instruction strobe |
| irq_n | input | 1 | Maskable interrupt request, active low |
| base_page_i | input | 8 | Interrupt base-page register value |
| bus_vec_i | input | 8 | Vector byte read from the data bus |
| refresh_load | input | 1 | Write strobe for the refresh register |
| refresh_din | input | 8 | Value written to the refresh register |
| take_o | output | 1 | Acceptance pulse, one clock |
| pv_o | output | 1 | Parity/overflow flag from the last base-page/refresh load |
| vec_ptr_o | output | 16 | Vectored-mode pointer captured at acceptance |
| wake_o | output | 1 | Halt release pulse |
| refresh_o | output | 8 | Refresh register value |

## Verification
Two functions can land on the same clock edge: acceptance of a request and the flag copy of a base-page/refresh load. The bench provokes this by enabling interrupts, letting the block window expire, and then issuing the load in its final clock with the request held low. The bench checks that take_o pulses and that pv_o reads 0 at that edge, while the same load with the request high reads 1. A long pseudo-random instruction stream also lets acceptance coincide with halt entry, disable, restore and refresh writes. Each outcome is judged against an arithmetic model of the requirements.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
   // Point at which a base-page/refresh load samples the backup enable.
   typedef enum bit {
      FLAG_BEFORE_TAKE = 1'b0,
      FLAG_AFTER_TAKE  = 1'b1
   } flag_sample_e;
endpackage

// File: rtl/irq_enable_ff.sv
module irq_enable_ff
   import irq_gate_pkg::*;
#(
   parameter flag_sample_e FLAG_MODE = FLAG_AFTER_TAKE
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_last,
   input  logic cmd_enable,
   input  logic cmd_disable,
   input  logic cmd_restore,
   input  logic cmd_ld_ir,
   input  logic irq_n,
   output logic accept_c,
   output logic take_q,
   output logic pv_q
);
   logic en_main;
   logic en_back;
   logic ei_window;
   logic flag_src;

   // Blocked in the final clock of the enable instruction and of the next one.
   assign accept_c = step_last & en_main & ~irq_n & ~ei_window & ~cmd_enable;

   generate
      if (FLAG_MODE == FLAG_AFTER_TAKE) begin : g_late_flag
         assign flag_src = accept_c ? 1'b0 : en_back;
      end else begin : g_early_flag
         assign flag_src = en_back;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_main   <= 1'b0;
         en_back   <= 1'b0;
         ei_window <= 1'b0;
         take_q    <= 1'b0;
         pv_q      <= 1'b0;
      end else begin
         take_q <= accept_c;
         if (accept_c) begin
            en_main <= 1'b0;
            en_back <= 1'b0;
         end else if (step_last) begin
            if (cmd_disable) begin
               en_main <= 1'b0;
               en_back <= 1'b0;
            end else if (cmd_enable) begin
               en_main <= 1'b1;
               en_back <= 1'b1;
            end else if (cmd_restore) begin
               en_main <= en_back;
            end
         end
         if (step_last) begin
            ei_window <= cmd_enable;
         end
         if (step_last && cmd_ld_ir) begin
            pv_q <= flag_src;
         end
      end
   end

   AST_TAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      take_q |=> !take_q); // R2
   AST_TAKE_CLEARS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      take_q |-> (!en_main && !en_back)); // R3
   AST_EI_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (step_last && cmd_enable) |=> !take_q); // R4
   AST_ENABLE_PAIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      en_main == en_back); // R5
endmodule

// File: rtl/irq_halt_vec.sv
module irq_halt_vec #(
   parameter int DATA_W = 8,
   localparam int PTR_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_last,
   input  logic              cmd_halt,
   input  logic              accept_c,
   input  logic [DATA_W-1:0] base_page_i,
   input  logic [DATA_W-1:0] bus_vec_i,
   output logic              wake_q,
   output logic [PTR_W-1:0]  ptr_q
);
   logic halted_q;
   logic halt_now;

   assign halt_now = step_last & cmd_halt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         wake_q   <= 1'b0;
         ptr_q    <= '0;
      end else begin
         wake_q <= accept_c & (halted_q | halt_now);
         if (accept_c) begin
            halted_q <= 1'b0;
            ptr_q    <= {base_page_i, bus_vec_i};
         end else if (halt_now) begin
            halted_q <= 1'b1;
         end
      end
   end

   AST_WAKE_LEAVES_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      wake_q |-> !halted_q); // R9
   AST_PTR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !accept_c |=> $stable(ptr_q)); // R7
endmodule

// File: rtl/irq_refresh_ctr.sv
module irq_refresh_ctr #(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_last,
   input  logic              load_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [DATA_W-1:0] r_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q <= '0;
      end else if (load_i) begin
         r_q <= din_i;
      end else if (step_last) begin
         r_q <= {r_q[DATA_W-1:CNT_W], r_q[CNT_W-1:0] + 1'b1};
      end
   end

   AST_REFRESH_TOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i) |=> (r_q[DATA_W-1:CNT_W] == $past(r_q[DATA_W-1:CNT_W]))); // R8
   AST_REFRESH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !step_last) |=> $stable(r_q)); // R8
endmodule

// File: rtl/cpu_irq_gate.sv
module cpu_irq_gate
   import irq_gate_pkg::*;
#(
   parameter int           DATA_W    = 8,
   parameter int           REFRESH_W = 7,
   parameter flag_sample_e FLAG_MODE = FLAG_AFTER_TAKE,
   localparam int          PTR_W     = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_last,
   input  logic              cmd_enable,
   input  logic              cmd_disable,
   input  logic              cmd_restore,
   input  logic              cmd_ld_ir,
   input  logic              cmd_halt,
   input  logic              irq_n,
   input  logic [DATA_W-1:0] base_page_i,
   input  logic [DATA_W-1:0] bus_vec_i,
   input  logic              refresh_load,
   input  logic [DATA_W-1:0] refresh_din,
   output logic              take_o,
   output logic              pv_o,
   output logic [PTR_W-1:0]  vec_ptr_o,
   output logic              wake_o,
   output logic [DATA_W-1:0] refresh_o
);
   generate
      if (REFRESH_W < 1 || REFRESH_W >= DATA_W) begin : g_bad_refresh_w
         $error("REFRESH_W must lie between 1 and DATA_W-1");
      end
      if (DATA_W < 2) begin : g_bad_data_w
         $error("DATA_W must be at least 2");
      end
   endgenerate

   logic accept_c;

   irq_enable_ff #(.FLAG_MODE(FLAG_MODE)) u_enable (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_last  (step_last),
      .cmd_enable (cmd_enable),
      .cmd_disable(cmd_disable),
      .cmd_restore(cmd_restore),
      .cmd_ld_ir  (cmd_ld_ir),
      .irq_n      (irq_n),
      .accept_c   (accept_c),
      .take_q     (take_o),
      .pv_q       (pv_o)
   );

   irq_halt_vec #(.DATA_W(DATA_W)) u_halt_vec (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_last  (step_last),
      .cmd_halt   (cmd_halt),
      .accept_c   (accept_c),
      .base_page_i(base_page_i),
      .bus_vec_i  (bus_vec_i),
      .wake_q     (wake_o),
      .ptr_q      (vec_ptr_o)
   );

   irq_refresh_ctr #(.DATA_W(DATA_W), .CNT_W(REFRESH_W)) u_refresh (
      .clk      (clk),
      .rst_n    (rst_n),
      .step_last(step_last),
      .load_i   (refresh_load),
      .din_i    (refresh_din),
      .r_q      (refresh_o)
   );

   AST_WAKE_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> take_o); // R9
   AST_NO_TAKE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_n || !step_last) |=> !take_o); // R2
   AST_COLLIDE_FLAG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (step_last && cmd_ld_ir && FLAG_MODE == FLAG_AFTER_TAKE) |=> (take_o -> !pv_o)); // R6
endmodule

// File: tb/cpu_irq_gate_tb.sv
module cpu_irq_gate_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic step_last = 1'b0, cmd_enable = 1'b0, cmd_disable = 1'b0, cmd_restore = 1'b0;
   logic cmd_ld_ir = 1'b0, cmd_halt = 1'b0, irq_n = 1'b1;
   logic [DW-1:0] base_page_i = '0, bus_vec_i = '0, refresh_din = '0;
   logic refresh_load = 1'b0;
   logic take_o, pv_o, wake_o;
   logic [2*DW-1:0] vec_ptr_o;
   logic [DW-1:0] refresh_o;

   int checks = 0;
   int errors = 0;

   // requirement model
   bit m_en, m_win, m_halt, m_take, m_wake, m_pv;
   logic [2*DW-1:0] m_ptr;
   logic [DW-1:0] m_r;

   always #(CLK_PERIOD/2) clk = ~clk;

   cpu_irq_gate dut_i (
      .clk(clk), .rst_n(rst_n), .step_last(step_last), .cmd_enable(cmd_enable),
      .cmd_disable(cmd_disable), .cmd_restore(cmd_restore), .cmd_ld_ir(cmd_ld_ir),
      .cmd_halt(cmd_halt), .irq_n(irq_n), .base_page_i(base_page_i),
      .bus_vec_i(bus_vec_i), .refresh_load(refresh_load), .refresh_din(refresh_din),
      .take_o(take_o), .pv_o(pv_o), .vec_ptr_o(vec_ptr_o), .wake_o(wake_o),
      .refresh_o(refresh_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Drive one clock at a falling edge, advance the model, compare at the next falling edge.
   task automatic step(input bit sd, input bit ei, input bit di, input bit rt,
                       input bit ld, input bit hl, input bit rq_n);
      bit acc;
      step_last = sd; cmd_enable = ei; cmd_disable = di; cmd_restore = rt;
      cmd_ld_ir = ld; cmd_halt = hl; irq_n = rq_n;
      acc = sd & m_en & ~rq_n & ~m_win & ~ei;
      m_take = acc;
      m_wake = acc & (m_halt | (sd & hl));
      if (sd && ld) m_pv = acc ? 1'b0 : m_en;
      if (acc) begin
         m_ptr = {base_page_i, bus_vec_i};
         m_en = 1'b0;
         m_halt = 1'b0;
      end else if (sd) begin
         if (di) m_en = 1'b0;
         else if (ei) m_en = 1'b1;
         if (hl) m_halt = 1'b1;
      end
      if (sd) m_win = ei;
      if (refresh_load) m_r = refresh_din;
      else if (sd) m_r = {m_r[7], 7'(m_r[6:0] + 7'd1)};
      @(posedge clk);
      @(negedge clk);
      chk("R2", "take_o", int'(take_o), int'(m_take));
      chk("R6", "pv_o", int'(pv_o), int'(m_pv));
      chk("R7", "vec_ptr_o", int'(vec_ptr_o), int'(m_ptr));
      chk("R9", "wake_o", int'(wake_o), int'(m_wake));
      chk("R8", "refresh_o", int'(refresh_o), int'(m_r));
   endtask

   task automatic nop(input bit rq_n);
      step(1, 0, 0, 0, 0, 0, rq_n);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      m_en = 0; m_win = 0; m_halt = 0; m_take = 0; m_wake = 0; m_pv = 0;
      m_ptr = '0; m_r = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1", "take_o", int'(take_o), 0);
      chk("R1", "wake_o", int'(wake_o), 0);
      chk("R1", "pv_o", int'(pv_o), 0);
      chk("R1", "vec_ptr_o", int'(vec_ptr_o), 0);
      chk("R1", "refresh_o", int'(refresh_o), 0);
      step(1, 0, 0, 0, 1, 0, 1);
      chk("R1", "pv after reset load", int'(pv_o), 0);

      // R4: enable blocks acceptance for itself and the next instruction
      base_page_i = 8'h80; bus_vec_i = 8'hFF;
      step(1, 1, 0, 0, 0, 0, 0);
      chk("R4", "take at enable", int'(take_o), 0);
      nop(0);
      chk("R4", "take after enable", int'(take_o), 0);
      step(0, 0, 0, 0, 0, 0, 0);
      chk("R2", "take without last cycle", int'(take_o), 0);
      nop(0);
      chk("R2", "take accepted", int'(take_o), 1);
      chk("R7", "pointer 80FF", int'(vec_ptr_o), 16'h80FF);
      // R3: cleared, held request not retaken
      nop(0);
      chk("R3", "no second take", int'(take_o), 0);
      step(1, 0, 0, 0, 1, 0, 1);
      chk("R3", "flag after take", int'(pv_o), 0);

      // R5: disable and restore
      step(1, 1, 0, 0, 0, 0, 1); nop(1);
      step(1, 0, 0, 0, 1, 0, 1);
      chk("R6", "flag when enabled", int'(pv_o), 1);
      step(1, 0, 1, 0, 0, 0, 1);
      step(1, 0, 0, 0, 1, 0, 1);
      chk("R5", "flag after disable", int'(pv_o), 0);
      step(1, 0, 0, 1, 0, 0, 1);
      step(1, 0, 0, 0, 1, 0, 0);
      chk("R5", "restore keeps disabled", int'(pv_o), 0);
      chk("R5", "no take while disabled", int'(take_o), 0);
      step(1, 1, 0, 0, 0, 0, 1); nop(1);
      step(1, 0, 0, 1, 0, 0, 1);
      step(1, 0, 0, 0, 1, 0, 1);
      chk("R5", "restore keeps enabled", int'(pv_o), 1);

      // R6: collision of acceptance and flag copy
      base_page_i = 8'h3C; bus_vec_i = 8'h12;
      step(1, 0, 0, 0, 1, 0, 0);
      chk("R6", "take in load", int'(take_o), 1);
      chk("R6", "collision flag", int'(pv_o), 0);
      chk("R7", "pointer 3C12", int'(vec_ptr_o), 16'h3C12);

      // R9: halt with interrupts disabled never wakes
      step(1, 0, 1, 0, 0, 0, 1);
      step(1, 0, 0, 0, 0, 1, 0);
      for (int i = 0; i < 40; i++) begin
         nop(0);
         chk("R9", "disabled halt wake", int'(wake_o), 0);
      end
      step(1, 1, 0, 0, 0, 0, 1); nop(1);
      nop(0);
      chk("R9", "wake from halt", int'(wake_o), 1);
      step(1, 1, 0, 0, 0, 0, 1); nop(1);
      step(1, 0, 0, 0, 0, 1, 0);
      chk("R9", "wake in halt clock", int'(wake_o), 1);

      // R8: refresh wrap keeps bit 7, load wins over increment
      refresh_load = 1'b1; refresh_din = 8'hFE;
      step(0, 0, 0, 0, 0, 0, 1);
      refresh_load = 1'b0;
      nop(1); nop(1);
      chk("R8", "refresh wrap", int'(refresh_o), 8'h80);
      refresh_load = 1'b1; refresh_din = 8'h7F;
      nop(1);
      refresh_load = 1'b0;
      chk("R8", "load priority", int'(refresh_o), 8'h7F);
      nop(1);
      chk("R8", "wrap with top clear", int'(refresh_o), 8'h00);

      // pseudo-random instruction stream against the model
      lfsr = 16'hACE1;
      for (int n = 0; n < 4000; n++) begin
         bit sd;
         bit [2:0] sel;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         sel = lfsr[2:0];
         sd = lfsr[3] | lfsr[4];
         base_page_i = lfsr[15:8];
         bus_vec_i = lfsr[7:0] ^ 8'h5A;
         refresh_load = (lfsr[7:4] == 4'h0);
         refresh_din = lfsr[12:5];
         step(sd, sel == 3'd0, sel == 3'd1, sel == 3'd4, sel == 3'd2,
              sel == 3'd3, lfsr[5] & lfsr[6]);
      end
      refresh_load = 1'b0;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule